// File: doc/BRIEF.md
# Register-Window Occupancy Controller

This block keeps the bookkeeping for a register file organised as a ring of overlapping windows. Four small counters describe how the ring is in use. One counts the windows free for new frames, one counts the windows holding restorable frames of the current context, one counts the windows that belong to another context, and one counts the windows already cleaned. Beside them sit a current-window pointer and a 6-bit trap-selection register. Each command updates this state in one clock. A command that cannot go ahead leaves the state untouched and instead reports an encoded trap number for the handler that must spill, fill or clean a window.

The pipeline issues one command per cycle on `cmd`. The commands are: open a frame, close a frame, flush check, and the two handler acknowledgements (one for a window written out, one for a window read back). A write command loads any single piece of state from `wr_data`. The counters and the pointer are always visible on the outputs. `trap_valid` pulses for one cycle, and that cycle matches the cycle in which the state would have changed.

Top module: `win_spill_ctrl`

## Requirements
- R1: After a synchronous reset, free-count equals NWIN-2, clean-count equals NWIN-1, the restorable count, other-context count, selection register and pointer are 0, and `trap_valid` is 0.
- R2: `cmd`=1 (open frame) with free-count 0 raises a spill trap and changes no state.
- R3: `cmd`=1 with free-count nonzero but clean-count equal to restorable count raises trap number 0x024 and changes no state.
- R4: A successful `cmd`=1 decrements free-count, increments restorable count and moves the pointer down by one, from 0 to NWIN-1.
- R5: `cmd`=2 (close frame) with restorable count 0 raises a fill trap with no state change; otherwise it increments free-count, decrements restorable count and moves the pointer up by one, from NWIN-1 to 0.
- R6: The spill number is 0x080 and the fill number 0x0C0, each ORed with an offset. When the other-context count is zero, the offset is selection bits 2:0 placed at bits 4:2. When it is nonzero, the offset is 0x020 ORed with selection bits 5:3 placed at bits 4:2.
- R7: `cmd`=3 (flush check) leaves all state unchanged. It raises the spill trap of R6 unless free-count equals NWIN-2.
- R8: `cmd`=4 (window written out) increments free-count. It then decrements the other-context count if that is nonzero, and otherwise decrements the restorable count.
- R9: `cmd`=5 (window read back) increments the restorable count. It increments clean-count only while clean-count is below NWIN-1. It then decrements the other-context count if that is nonzero, and otherwise decrements free-count.
- R10: `cmd`=6 writes `wr_data` into the item chosen by `wr_sel`: 0 free, 1 restorable, 2 other-context, 3 clean, 4 pointer, 5 selection register (low 6 bits). For selections 0 to 4, a value of NWIN or more is ignored, and selections 6 and 7 are ignored.
- R11: State updates and `trap_valid`/`trap_type` appear at the first clock edge after the command. `trap_type` is 0 whenever `trap_valid` is 0. Counter arithmetic wraps modulo 2^CW.
- R12: `cmd` values 0 and 7 change nothing and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code |
| wr_sel | input | 3 | Target of a write command |
| wr_data | input | DATA_W | Value for a write command |
| cansave_o | output | CW | Free-window count |
| canrestore_o | output | CW | Restorable-window count |
| otherwin_o | output | CW | Other-context window count |
| cleanwin_o | output | CW | Clean-window count |
| cwp_o | output | CW | Current window pointer |
| wstate_o | output | 6 | Trap-selection register |
| trap_valid | output | 1 | One-cycle trap indication |
| trap_type | output | 9 | Encoded trap number |

## Verification
On every cycle the assertions check several properties. A trapped command freezes all state. An idle trap output reads zero. The pointer stays inside the ring and wraps correctly on a frame open. Free and restorable counts move in opposite directions on open and close. Clean-count holds at its ceiling during a read-back. The composition of trap numbers from the selection fields can only be shown by the bench's scenarios, because it depends on the other-context count. The same holds for the choice between the spill and clean-window outcomes, the flush test against NWIN-2, and the rejection of out-of-range writes, which needs a ring size that is not a power of two.

// File: rtl/winctl_pkg.sv
package winctl_pkg;

    localparam int TT_W = 9;

    localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [TT_W-1:0] TT_CLEAN      = 9'h024;
    localparam logic [TT_W-1:0] TT_OTHER_FLAG = 9'h020;

    typedef enum logic [2:0] {
        CMD_IDLE     = 3'd0,
        CMD_OPEN     = 3'd1,
        CMD_CLOSE    = 3'd2,
        CMD_FLUSH    = 3'd3,
        CMD_WROTE    = 3'd4,
        CMD_READBACK = 3'd5,
        CMD_WRITE    = 3'd6,
        CMD_RSVD     = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        SEL_FREE   = 3'd0,
        SEL_REST   = 3'd1,
        SEL_OTHER  = 3'd2,
        SEL_CLEAN  = 3'd3,
        SEL_PTR    = 3'd4,
        SEL_SELREG = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } wsel_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_OPEN,
        ACT_CLOSE,
        ACT_WROTE,
        ACT_READBACK,
        ACT_WRITE,
        ACT_TRAP
    } act_e;

    typedef struct packed {
        act_e            kind;
        logic [TT_W-1:0] tt;
    } action_t;

    // Spill/fill number: base code plus an offset picked by the other-context state
    function automatic logic [TT_W-1:0] compose_tt(
        input logic [TT_W-1:0] base,
        input logic            other_present,
        input logic [5:0]      selreg
    );
        logic [TT_W-1:0] off;
        if (other_present)
            off = TT_OTHER_FLAG | {4'b0000, selreg[5:3], 2'b00};
        else
            off = {4'b0000, selreg[2:0], 2'b00};
        return base | off;
    endfunction

endpackage

// File: rtl/winctl_decode.sv
module winctl_decode
    import winctl_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  cmd_e          cmd,
    input  logic [CW-1:0] cansave,
    input  logic [CW-1:0] canrestore,
    input  logic [CW-1:0] otherwin,
    input  logic [CW-1:0] cleanwin,
    input  logic [5:0]    wstate,
    output action_t       act
);
    localparam logic [CW-1:0] FLUSH_FREE = CW'(NWIN - 2);

    logic            other_present;
    logic [TT_W-1:0] spill_tt;
    logic [TT_W-1:0] fill_tt;

    assign other_present = (otherwin != '0);
    assign spill_tt      = compose_tt(TT_SPILL_BASE, other_present, wstate);
    assign fill_tt       = compose_tt(TT_FILL_BASE,  other_present, wstate);

    always_comb begin
        act.kind = ACT_NONE;
        act.tt   = '0;
        unique case (cmd)
            CMD_OPEN: begin
                if (cansave == '0) begin
                    act.kind = ACT_TRAP;
                    act.tt   = spill_tt;
                end else if (cleanwin == canrestore) begin
                    act.kind = ACT_TRAP;
                    act.tt   = TT_CLEAN;
                end else begin
                    act.kind = ACT_OPEN;
                end
            end
            CMD_CLOSE: begin
                if (canrestore == '0) begin
                    act.kind = ACT_TRAP;
                    act.tt   = fill_tt;
                end else begin
                    act.kind = ACT_CLOSE;
                end
            end
            CMD_FLUSH: begin
                if (cansave != FLUSH_FREE) begin
                    act.kind = ACT_TRAP;
                    act.tt   = spill_tt;
                end
            end
            CMD_WROTE:    act.kind = ACT_WROTE;
            CMD_READBACK: act.kind = ACT_READBACK;
            CMD_WRITE:    act.kind = ACT_WRITE;
            default:      act.kind = ACT_NONE;
        endcase
    end

    always_comb begin
        if (act.kind != ACT_TRAP)
            assert_tt_quiet_R11: assert (act.tt == '0);
    end
endmodule

// File: rtl/winctl_counters.sv
module winctl_counters
    import winctl_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  action_t           act,
    input  wsel_e             wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     cansave,
    output logic [CW-1:0]     canrestore,
    output logic [CW-1:0]     otherwin,
    output logic [CW-1:0]     cleanwin,
    output logic [5:0]        wstate
);
    localparam logic [CW-1:0] RST_FREE  = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_CAP = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    logic [CW-1:0] cs_n, cr_n, ow_n, cw_n;
    logic [5:0]    ws_n;
    logic          wr_ok;
    logic [CW-1:0] wr_val;

    assign wr_ok  = (wr_data < DATA_W'(NWIN));
    assign wr_val = wr_data[CW-1:0];

    always_comb begin
        cs_n = cansave;
        cr_n = canrestore;
        ow_n = otherwin;
        cw_n = cleanwin;
        ws_n = wstate;
        unique case (act.kind)
            ACT_OPEN: begin
                cs_n = cansave - ONE;
                cr_n = canrestore + ONE;
            end
            ACT_CLOSE: begin
                cs_n = cansave + ONE;
                cr_n = canrestore - ONE;
            end
            ACT_WROTE: begin
                cs_n = cansave + ONE;
                if (otherwin != '0) ow_n = otherwin - ONE;
                else                cr_n = canrestore - ONE;
            end
            ACT_READBACK: begin
                cr_n = canrestore + ONE;
                if (cleanwin < CLEAN_CAP) cw_n = cleanwin + ONE;
                if (otherwin != '0) ow_n = otherwin - ONE;
                else                cs_n = cansave - ONE;
            end
            ACT_WRITE: begin
                unique case (wr_sel)
                    SEL_FREE:   if (wr_ok) cs_n = wr_val;
                    SEL_REST:   if (wr_ok) cr_n = wr_val;
                    SEL_OTHER:  if (wr_ok) ow_n = wr_val;
                    SEL_CLEAN:  if (wr_ok) cw_n = wr_val;
                    SEL_SELREG: ws_n = wr_data[5:0];
                    default:    ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cansave    <= RST_FREE;
            canrestore <= '0;
            otherwin   <= '0;
            cleanwin   <= CLEAN_CAP;
            wstate     <= '0;
        end else begin
            cansave    <= cs_n;
            canrestore <= cr_n;
            otherwin   <= ow_n;
            cleanwin   <= cw_n;
            wstate     <= ws_n;
        end
    end

    assert_open_moves_R4: assert property (@(posedge clk) disable iff (rst)
        act.kind == ACT_OPEN |=>
            (cansave == $past(cansave) - ONE) && (canrestore == $past(canrestore) + ONE));

    assert_close_moves_R5: assert property (@(posedge clk) disable iff (rst)
        act.kind == ACT_CLOSE |=>
            (cansave == $past(cansave) + ONE) && (canrestore == $past(canrestore) - ONE));

    assert_wrote_other_R8: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_WROTE && otherwin != '0) |=>
            (otherwin == $past(otherwin) - ONE) && $stable(canrestore));

    assert_clean_cap_R9: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_READBACK && cleanwin == CLEAN_CAP) |=> $stable(cleanwin));
endmodule

// File: rtl/winctl_ptr.sv
module winctl_ptr
    import winctl_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  action_t           act,
    input  wsel_e             wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     cwp
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic [CW-1:0] cwp_n;

    always_comb begin
        cwp_n = cwp;
        unique case (act.kind)
            ACT_OPEN:  cwp_n = (cwp == '0)   ? LAST : cwp - CW'(1);
            ACT_CLOSE: cwp_n = (cwp == LAST) ? '0   : cwp + CW'(1);
            ACT_WRITE: if (wr_sel == SEL_PTR && wr_data < DATA_W'(NWIN))
                           cwp_n = wr_data[CW-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cwp <= '0;
        else     cwp <= cwp_n;
    end

    assert_ptr_in_ring_R10: assert property (@(posedge clk) disable iff (rst)
        cwp <= LAST);

    assert_open_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_OPEN && cwp == '0) |=> cwp == LAST);

    assert_close_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_CLOSE && cwp == LAST) |=> cwp == '0);
endmodule

// File: rtl/win_spill_ctrl.sv
module win_spill_ctrl
    import winctl_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int DATA_W = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     cansave_o,
    output logic [CW-1:0]     canrestore_o,
    output logic [CW-1:0]     otherwin_o,
    output logic [CW-1:0]     cleanwin_o,
    output logic [CW-1:0]     cwp_o,
    output logic [5:0]        wstate_o,
    output logic              trap_valid,
    output logic [8:0]        trap_type
);
    action_t act;

    winctl_decode #(.NWIN(NWIN)) u_decode (
        .cmd        (cmd_e'(cmd)),
        .cansave    (cansave_o),
        .canrestore (canrestore_o),
        .otherwin   (otherwin_o),
        .cleanwin   (cleanwin_o),
        .wstate     (wstate_o),
        .act        (act)
    );

    winctl_counters #(.NWIN(NWIN), .DATA_W(DATA_W)) u_counters (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .wr_sel     (wsel_e'(wr_sel)),
        .wr_data    (wr_data),
        .cansave    (cansave_o),
        .canrestore (canrestore_o),
        .otherwin   (otherwin_o),
        .cleanwin   (cleanwin_o),
        .wstate     (wstate_o)
    );

    winctl_ptr #(.NWIN(NWIN), .DATA_W(DATA_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wr_sel  (wsel_e'(wr_sel)),
        .wr_data (wr_data),
        .cwp     (cwp_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_valid <= 1'b0;
            trap_type  <= '0;
        end else begin
            trap_valid <= (act.kind == ACT_TRAP);
            trap_type  <= act.tt;
        end
    end

    assert_trap_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> ($stable(cansave_o) && $stable(canrestore_o) && $stable(otherwin_o)
                        && $stable(cleanwin_o) && $stable(cwp_o)));

    assert_idle_type_R11: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> trap_type == '0);

    assert_flush_static_R7: assert property (@(posedge clk) disable iff (rst)
        cmd == 3'd3 |=> ($stable(cansave_o) && $stable(canrestore_o) && $stable(cwp_o)));
endmodule

// File: tb/tb_win_spill_ctrl.sv
module tb_win_spill_ctrl;
    localparam int N  = 6;
    localparam int DW = 8;
    localparam int CW = $clog2(N);
    localparam int M  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst;
    logic [2:0] cmd, wr_sel;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] cs_o, cr_o, ow_o, cw_o, cwp_o;
    logic [5:0] ws_o;
    logic tv_o;
    logic [8:0] tt_o;

    int checks = 0, errors = 0;
    int m_cs, m_cr, m_ow, m_cw, m_cwp, m_ws, m_tv, m_tt;

    always #5 clk = ~clk;

    win_spill_ctrl #(.NWIN(N), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .wr_sel(wr_sel), .wr_data(wr_data),
        .cansave_o(cs_o), .canrestore_o(cr_o), .otherwin_o(ow_o), .cleanwin_o(cw_o),
        .cwp_o(cwp_o), .wstate_o(ws_o), .trap_valid(tv_o), .trap_type(tt_o)
    );

    function automatic int vec(input int base, input int ow, input int ws);
        if (ow != 0) return base | 32'h20 | (((ws >> 3) & 7) << 2);
        return base | ((ws & 7) << 2);
    endfunction

    task automatic model(input int c, input int s, input int d, output string req);
        m_tv = 0; m_tt = 0; req = "R12";
        case (c)
            1: if (m_cs == 0) begin m_tv = 1; m_tt = vec(32'h80, m_ow, m_ws); req = "R2"; end
               else if (m_cw == m_cr) begin m_tv = 1; m_tt = 32'h24; req = "R3"; end
               else begin
                   m_cs = (m_cs - 1) & M; m_cr = (m_cr + 1) & M;
                   m_cwp = (m_cwp == 0) ? N - 1 : m_cwp - 1; req = "R4";
               end
            2: begin
                req = "R5";
                if (m_cr == 0) begin m_tv = 1; m_tt = vec(32'hC0, m_ow, m_ws); end
                else begin
                    m_cs = (m_cs + 1) & M; m_cr = (m_cr - 1) & M;
                    m_cwp = (m_cwp == N - 1) ? 0 : m_cwp + 1;
                end
            end
            3: begin
                req = "R7";
                if (m_cs != N - 2) begin m_tv = 1; m_tt = vec(32'h80, m_ow, m_ws); end
            end
            4: begin
                req = "R8";
                m_cs = (m_cs + 1) & M;
                if (m_ow != 0) m_ow = (m_ow - 1) & M; else m_cr = (m_cr - 1) & M;
            end
            5: begin
                req = "R9";
                m_cr = (m_cr + 1) & M;
                if (m_cw < N - 1) m_cw = m_cw + 1;
                if (m_ow != 0) m_ow = (m_ow - 1) & M; else m_cs = (m_cs - 1) & M;
            end
            6: begin
                req = "R10";
                if (s == 5) m_ws = d & 63;
                else if (d < N) case (s)
                    0: m_cs = d; 1: m_cr = d; 2: m_ow = d; 3: m_cw = d; 4: m_cwp = d;
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        checks++;
        if (int'(cs_o) != m_cs || int'(cr_o) != m_cr || int'(ow_o) != m_ow ||
            int'(cw_o) != m_cw || int'(cwp_o) != m_cwp || int'(ws_o) != m_ws ||
            int'(tv_o) != m_tv || int'(tt_o) != m_tt) begin
            errors++;
            $display("FAIL %s: got cs=%0d cr=%0d ow=%0d cw=%0d cwp=%0d ws=%0h tv=%0d tt=%0h, exp cs=%0d cr=%0d ow=%0d cw=%0d cwp=%0d ws=%0h tv=%0d tt=%0h",
                     req, cs_o, cr_o, ow_o, cw_o, cwp_o, ws_o, tv_o, tt_o,
                     m_cs, m_cr, m_ow, m_cw, m_cwp, m_ws, m_tv, m_tt);
        end
    endtask

    // Drive on a falling edge, check after the next rising edge (one register stage)
    task automatic step(input int c, input int s, input int d, input string tag);
        string req;
        cmd = 3'(c); wr_sel = 3'(s); wr_data = DW'(d);
        model(c, s, d, req);
        @(negedge clk);
        compare(tag == "" ? req : tag);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; cmd = '0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cs = N - 2; m_cr = 0; m_ow = 0; m_cw = N - 1; m_cwp = 0; m_ws = 0; m_tv = 0; m_tt = 0;
        compare("R1 reset");

        step(3, 0, 0, "R7 flush at reset level");
        for (int i = 0; i < N - 2; i++) step(1, 0, 0, "R4 open");
        step(1, 0, 0, "R2 spill when no free window");
        step(6, 5, 8'h2B, "R10 selector write");
        step(1, 0, 0, "R6 spill vector from low selector bits");
        step(6, 2, 2, "R10 other-context write");
        step(1, 0, 0, "R6 spill vector with other flag");
        step(3, 0, 0, "R7 flush traps");
        step(4, 0, 0, "R8 written out uses other-context");
        step(6, 3, 4, "R10 clean write");
        step(1, 0, 0, "R3 clean-window trap");
        step(6, 4, 7, "R10 out-of-range pointer ignored");
        step(6, 0, 6, "R10 out-of-range count ignored");
        step(6, 7, 1, "R10 reserved select ignored");
        step(7, 0, 0, "R12 reserved command");
        step(0, 0, 0, "R12 idle");
        for (int i = 0; i < 6; i++) step(2, 0, 0, "R5 close then fill");
        step(6, 3, 5, "R10 clean at cap");
        step(5, 0, 0, "R9 readback at clean cap");
        step(6, 4, 5, "R10 pointer to last");
        step(6, 1, 1, "R10 restorable write");
        step(2, 0, 0, "R5 close wraps pointer");
        step(2, 0, 0, "R11 fill pulse");
        step(0, 0, 0, "R11 trap drops");

        for (int i = 0; i < 1500; i++) begin
            int c, s, d;
            c = $urandom % 8;
            s = $urandom % 8;
            d = (s == 5) ? ($urandom % 64) : ($urandom % 8);
            step(c, s, d, "");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule